// File: doc/BRIEF.md
# Circular Buffer Burst Writer

This block takes a stream of 64-bit words from a producer. It writes them into a ring-shaped region of memory as burst write commands. Software sets the region by a base address, an end address and a limit address, all 128-byte aligned. The block keeps its own write pointer, which is 8-byte aligned. After a completed burst the pointer moves forward, and when it lands on the end address it returns to the base. The writer never moves the pointer onto or beyond the limit. Software moves the limit forward as it consumes data from the ring.

A queue of 1024 words sits at the input. Full bursts are 16 words. When fewer words than a full burst wait in the queue and no new word has arrived for 256 cycles, the words present go out as a shorter burst. A burst is also shortened so that it never runs past the end address. One burst is in flight at a time: a command handshake, then one word per cycle on which the memory side raises its data-ready, then a completion pulse.

An interrupt latch sets when the interrupt is enabled and a completed burst carries the pointer onto or across a programmed 8-byte address. The latch stays set until software clears it.

Top module: `ring_dma_writer`

## Requirements
- R1: Reset sets the write pointer to zero. A one-cycle init pulse while no burst is in flight loads the pointer with the base address in the next cycle.
- R2: A command carries the current pointer as its address and the word count as its length (1 to 16). The data words follow in queue order, one for each cycle with data-ready high.
- R3: The pointer changes only on the completion pulse, and it advances by the burst length. A result equal to the end address becomes the base address.
- R4: A burst never runs past the end address. Its length is at most 16 and at most the distance from the pointer to the end. When at least that many words are queued, the burst is issued without waiting.
- R5: A burst is issued only when its length is strictly below the circular distance from the pointer to the limit. When the limit is above the pointer, that distance is limit minus pointer. Otherwise it is (end minus pointer) plus (limit minus base).
- R6: When fewer words than the needed length are queued, nothing is issued until 256 cycles pass with no new input. Then the queued words are issued as one shorter burst.
- R7: With the interrupt enabled, a completion that moves the pointer from below the interrupt address to at or above it sets the interrupt output. So does a wrap onto a base equal to that address. The output holds until a clear pulse drops it.
- R8: While enable is low, no new command is issued. A command already issued stays valid and completes.
- R9: Busy is high while a burst is in flight or the queue holds words. Queue-empty is high exactly when the queue holds no word.
- R10: Input ready drops when the queue holds 1024 words. An input word offered while ready is low is not stored.
- R11: A command that is not accepted keeps its address and length unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en | input | 1 | Allows new burst commands |
| chan_init | input | 1 | One-cycle pulse: load pointer with base |
| buf_start | input | 25 | Ring base, byte address bits 31..7 |
| buf_end | input | 25 | Ring end (exclusive), bits 31..7 |
| buf_limit | input | 25 | Limit the pointer may not reach, bits 31..7 |
| irq_addr | input | 29 | Interrupt address, bits 31..3 |
| irq_en | input | 1 | Interrupt enable |
| irq_clear | input | 1 | One-cycle pulse: clear pending interrupt |
| irq_out | output | 1 | Pending interrupt |
| wr_ptr | output | 29 | Write pointer, byte address bits 31..3 |
| busy | output | 1 | Burst in flight or words queued |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Queue can take a word |
| in_empty | output | 1 | Queue holds no word |
| in_data | input | 64 | Input word |
| cmd_addr | output | 29 | Burst address, bits 31..3 |
| cmd_len | output | 5 | Burst length in words, 1 to 16 |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command accepted |
| wdata | output | 64 | Current burst data word |
| wdata_ready | input | 1 | Memory side takes wdata this cycle |
| wr_done | input | 1 | Completion pulse of the burst in flight |

## Verification
The assertions assume that the base, end and limit form a valid ring (base below end, limit inside it). They also assume that the end address does not change while a command waits. The memory side must raise data-ready only between command acceptance and the last word, and completion only after the last word. The bench's memory model keeps to this order. It changes the limit only while no command is offered, and it changes the ring bounds only before the first init. The limit changes in the stall and wrap scenarios are made on 16-word boundaries inside the ring.

// File: rtl/rdw_pkg.sv
package rdw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } rdw_state_e;
endpackage

// File: rtl/rdw_queue.sv
module rdw_queue #(
  parameter int DATA_W    = 64,
  parameter int DEPTH_LOG = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic [DEPTH_LOG:0] count,
  output logic              full,
  output logic              empty
);
  localparam int DEPTH = 1 << DEPTH_LOG;
  localparam logic [DEPTH_LOG:0] CNT_FULL = (DEPTH_LOG+1)'(DEPTH);

  logic [DATA_W-1:0]    mem [DEPTH];
  logic [DEPTH_LOG-1:0] wi_q, wi_n, ri_q, ri_n;
  logic [DEPTH_LOG:0]   cnt_q, cnt_n;
  logic                 do_push, do_pop;

  assign full    = (cnt_q == CNT_FULL);
  assign empty   = (cnt_q == '0);
  assign count   = cnt_q;
  assign dout    = mem[ri_q];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wi_n  = wi_q;
    ri_n  = ri_q;
    cnt_n = cnt_q;
    if (do_push) wi_n = wi_q + 1'b1;
    if (do_pop)  ri_n = ri_q + 1'b1;
    if (do_push && !do_pop)      cnt_n = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wi_q  <= '0;
      ri_q  <= '0;
      cnt_q <= '0;
    end else begin
      wi_q  <= wi_n;
      ri_q  <= ri_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wi_q] <= din;
  end

  // R10: occupancy never exceeds the depth
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  // R2: the controller only takes words that exist
  p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R10: a full queue does not grow in the next cycle
  p_full_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
endmodule

// File: rtl/rdw_span.sv
module rdw_span #(
  parameter int WA_W  = 29,
  parameter int LEN_W = 5,
  parameter int CNT_W = 11
) (
  input  logic [WA_W-1:0]  ptr,
  input  logic [WA_W-1:0]  base,
  input  logic [WA_W-1:0]  top,
  input  logic [WA_W-1:0]  lim,
  input  logic [CNT_W-1:0] avail,
  input  logic             flush_ok,
  output logic             go,
  output logic [LEN_W-1:0] len
);
  localparam int BW = 1 << (LEN_W-1);
  localparam logic [WA_W-1:0]  BW_A = WA_W'(BW);
  localparam logic [LEN_W-1:0] BW_L = LEN_W'(BW);

  logic [WA_W-1:0]  to_end;
  logic [WA_W:0]    room;
  logic [LEN_W-1:0] want, take;
  logic             full_ok, enough, fits;

  always_comb begin
    to_end  = top - ptr;
    want    = (to_end >= BW_A) ? BW_L : to_end[LEN_W-1:0];
    full_ok = (avail >= CNT_W'(want));
    take    = full_ok ? want : avail[LEN_W-1:0];
    enough  = (want != '0) && (full_ok || (flush_ok && (avail != '0)));
    if (lim > ptr)
      room = {1'b0, lim} - {1'b0, ptr};
    else
      room = ({1'b0, top} - {1'b0, ptr}) + ({1'b0, lim} - {1'b0, base});
    fits = ((WA_W+1)'(take) < room);
    go   = enough && fits;
    len  = take;
  end
endmodule

// File: rtl/rdw_irq.sv
module rdw_irq #(
  parameter int WA_W = 29
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            clr,
  input  logic            adv,
  input  logic [WA_W-1:0] old_ptr,
  input  logic [WA_W-1:0] raw_ptr,
  input  logic            wrapped,
  input  logic [WA_W-1:0] base,
  input  logic [WA_W-1:0] target,
  output logic            pend
);
  logic pend_q, pend_n, hit;

  always_comb begin
    hit = ((old_ptr < target) && (target <= raw_ptr)) ||
          (wrapped && (target == base));
    pend_n = pend_q;
    if (clr) pend_n = 1'b0;
    if (adv && en && hit) pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_n;
  end

  assign pend = pend_q;

  // R7: a pending interrupt holds until cleared
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr) |=> pend_q);

  // R7: nothing sets the latch without an enabled advance
  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !(adv && en)) |=> !pend_q);
endmodule

// File: rtl/ring_dma_writer.sv
module ring_dma_writer
  import rdw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int BURST_LOG = 4,
  parameter int QUEUE_LOG = 10,
  parameter int IDLE_CYC  = 256
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        chan_en,
  input  logic                        chan_init,
  input  logic [ADDR_W-1:BURST_LOG+3] buf_start,
  input  logic [ADDR_W-1:BURST_LOG+3] buf_end,
  input  logic [ADDR_W-1:BURST_LOG+3] buf_limit,
  input  logic [ADDR_W-1:3]           irq_addr,
  input  logic                        irq_en,
  input  logic                        irq_clear,
  output logic                        irq_out,
  output logic [ADDR_W-1:3]           wr_ptr,
  output logic                        busy,
  input  logic                        in_valid,
  output logic                        in_ready,
  output logic                        in_empty,
  input  logic [DATA_W-1:0]           in_data,
  output logic [ADDR_W-1:3]           cmd_addr,
  output logic [BURST_LOG:0]          cmd_len,
  output logic                        cmd_valid,
  input  logic                        cmd_ready,
  output logic [DATA_W-1:0]           wdata,
  input  logic                        wdata_ready,
  input  logic                        wr_done
);
  localparam int WA_W  = ADDR_W - 3;
  localparam int LEN_W = BURST_LOG + 1;
  localparam int CNT_W = QUEUE_LOG + 1;
  localparam int TMR_W = $clog2(IDLE_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_MAX = TMR_W'(IDLE_CYC);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(1 << BURST_LOG);

  rdw_state_e       st_q, st_n;
  logic [WA_W-1:0]  ptr_q, ptr_n;
  logic [LEN_W-1:0] len_q, len_n, rem_q, rem_n;
  logic [TMR_W-1:0] tmr_q, tmr_n;

  logic [WA_W-1:0]  start_w, end_w, lim_w, raw_ptr, adv_ptr;
  logic             wrapped, adv;
  logic [CNT_W-1:0] q_count;
  logic             q_full, q_empty, q_pop, push_ok;
  logic             span_go, flush_ok;
  logic [LEN_W-1:0] span_len;

  assign start_w = {buf_start, {BURST_LOG{1'b0}}};
  assign end_w   = {buf_end,   {BURST_LOG{1'b0}}};
  assign lim_w   = {buf_limit, {BURST_LOG{1'b0}}};

  // Input queue
  assign push_ok = in_valid && !q_full;
  assign q_pop   = (st_q == ST_DATA) && wdata_ready;

  rdw_queue #(.DATA_W(DATA_W), .DEPTH_LOG(QUEUE_LOG)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (in_valid),
    .din   (in_data),
    .pop   (q_pop),
    .dout  (wdata),
    .count (q_count),
    .full  (q_full),
    .empty (q_empty)
  );

  // Burst sizing against end and limit
  assign flush_ok = (tmr_q == TMR_MAX);

  rdw_span #(.WA_W(WA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_span (
    .ptr      (ptr_q),
    .base     (start_w),
    .top      (end_w),
    .lim      (lim_w),
    .avail    (q_count),
    .flush_ok (flush_ok),
    .go       (span_go),
    .len      (span_len)
  );

  // Pointer advance and wrap
  assign raw_ptr = ptr_q + WA_W'(len_q);
  assign wrapped = (raw_ptr == end_w);
  assign adv_ptr = wrapped ? start_w : raw_ptr;
  assign adv     = (st_q == ST_DONE) && wr_done;

  rdw_irq #(.WA_W(WA_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (irq_en),
    .clr     (irq_clear),
    .adv     (adv),
    .old_ptr (ptr_q),
    .raw_ptr (raw_ptr),
    .wrapped (wrapped),
    .base    (start_w),
    .target  (irq_addr),
    .pend    (irq_out)
  );

  // Controller next state
  always_comb begin
    st_n  = st_q;
    ptr_n = ptr_q;
    len_n = len_q;
    rem_n = rem_q;
    unique case (st_q)
      ST_IDLE: begin
        if (chan_init) begin
          ptr_n = start_w;
        end else if (chan_en && span_go) begin
          len_n = span_len;
          st_n  = ST_CMD;
        end
      end
      ST_CMD: begin
        if (cmd_ready) begin
          rem_n = len_q;
          st_n  = ST_DATA;
        end
      end
      ST_DATA: begin
        if (q_pop) begin
          rem_n = rem_q - 1'b1;
          if (rem_q == LEN_W'(1)) st_n = ST_DONE;
        end
      end
      ST_DONE: begin
        if (wr_done) begin
          ptr_n = adv_ptr;
          st_n  = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // Idle timer: restarts on every accepted word or an empty queue
  always_comb begin
    tmr_n = tmr_q;
    if (push_ok || q_empty)   tmr_n = '0;
    else if (tmr_q != TMR_MAX) tmr_n = tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ptr_q <= '0;
      len_q <= '0;
      rem_q <= '0;
      tmr_q <= '0;
    end else begin
      st_q  <= st_n;
      ptr_q <= ptr_n;
      len_q <= len_n;
      rem_q <= rem_n;
      tmr_q <= tmr_n;
    end
  end

  assign wr_ptr    = ptr_q;
  assign cmd_addr  = ptr_q;
  assign cmd_len   = len_q;
  assign cmd_valid = (st_q == ST_CMD);
  assign in_ready  = !q_full;
  assign in_empty  = q_empty;
  assign busy      = (st_q != ST_IDLE) || !q_empty;

  // R11: an offered command holds until accepted
  p_cmd_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_len)));

  // R4: length range and no run past the end
  p_fits_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ((cmd_len != '0) && (cmd_len <= LEN_MAX) &&
                   (({1'b0, cmd_addr} + (WA_W+1)'(cmd_len)) <= {1'b0, end_w})));

  // R8: with enable low an idle writer offers nothing
  p_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && !chan_en) |=> !cmd_valid);

  // R3: the pointer moves only on completion or init
  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !chan_init) |=> $stable(wr_ptr));

  // R9: busy whenever words are queued
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_empty |-> busy);
endmodule

// File: tb/ring_dma_writer_test.sv
module ring_dma_writer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_en = 1'b0, chan_init = 1'b0;
  logic [31:7] b_start = '0, b_end = '0, b_limit = '0;
  logic [31:3] irq_addr = '0;
  logic        irq_en = 1'b0, irq_clear = 1'b0;
  logic        irq_out, busy, in_ready, in_empty, cmd_valid;
  logic [31:3] wr_ptr, cmd_addr;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0, wdata;
  logic [4:0]  cmd_len;
  logic        cmd_ready = 1'b0, wdata_ready = 1'b0, wr_done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_dma_writer uut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .chan_init(chan_init),
    .buf_start(b_start), .buf_end(b_end), .buf_limit(b_limit),
    .irq_addr(irq_addr), .irq_en(irq_en), .irq_clear(irq_clear), .irq_out(irq_out),
    .wr_ptr(wr_ptr), .busy(busy), .in_valid(in_valid), .in_ready(in_ready),
    .in_empty(in_empty), .in_data(in_data), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .wdata(wdata),
    .wdata_ready(wdata_ready), .wr_done(wr_done)
  );

  int checks = 0, errors = 0;
  logic [63:0] exp_q[$];
  int mptr = 0, mstart = 0, mend = 0;
  int bursts = 0, last_len = 0, seq = 0;
  bit sink_on = 1'b0, auto_lim = 1'b0, finished = 1'b0;
  int s_len, s_room, s_lim, s_cap;
  logic [63:0] s_exp;
  logic [31:3] held_addr;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic set_lim(input int w);
    b_limit = 25'(w >> 4);
  endtask

  task automatic push_word();
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    seq++;
    in_data  = {32'hA5A50000 + 32'(seq), ~32'(seq)};
    in_valid = 1'b1;
    exp_q.push_back(in_data);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) push_word();
  endtask

  task automatic wait_bursts(input int target, input int limit_cyc);
    for (int i = 0; i < limit_cyc && bursts < target; i++) @(negedge clk);
    chk(bursts == target, "R2 burst count", bursts, target);
  endtask

  // Memory-side model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (sink_on && cmd_valid) begin
        s_len = int'(cmd_len);
        chk(int'(cmd_addr) == mptr, "R2 cmd address", cmd_addr, mptr);
        s_cap = (mend - mptr) < 16 ? (mend - mptr) : 16;
        chk(s_len >= 1 && s_len <= s_cap, "R4 burst length", s_len, s_cap);
        s_lim = int'({b_limit, 4'b0});
        s_room = (s_lim > mptr) ? (s_lim - mptr) : ((mend - mptr) + (s_lim - mstart));
        chk(s_len < s_room, "R5 limit room", s_len, s_room);
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        for (int i = 0; i < s_len; i++) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected data word", wdata, 0);
          end else begin
            s_exp = exp_q.pop_front();
            chk(wdata == s_exp, "R2 data order", wdata, s_exp);
          end
          wdata_ready = 1'b1;
          @(negedge clk);
        end
        wdata_ready = 1'b0;
        repeat (2) @(negedge clk);
        wr_done = 1'b1;
        @(negedge clk);
        wr_done = 1'b0;
        mptr = mptr + s_len;
        if (mptr == mend) mptr = mstart;
        chk(int'(wr_ptr) == mptr, "R3 pointer after completion", wr_ptr, mptr);
        last_len = s_len;
        bursts++;
        if (auto_lim) set_lim(mptr);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    if (!finished) $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R9 reset state
    chk(wr_ptr == '0, "R1 reset pointer", wr_ptr, 0);
    chk(!cmd_valid, "R8 no command after reset", cmd_valid, 0);
    chk(!busy && in_empty, "R9 idle after reset", {busy, in_empty}, 1);
    chk(in_ready && !irq_out, "R10 ready after reset", {in_ready, irq_out}, 2);

    mstart = 32'h1000 >> 3;
    mend   = 32'h1400 >> 3;
    b_start = 25'(32'h1000 >> 7);
    b_end   = 25'(32'h1400 >> 7);
    set_lim(32'h1380 >> 3);
    @(negedge clk);
    chan_init = 1'b1;
    @(negedge clk);
    chan_init = 1'b0;
    mptr = mstart;
    chk(int'(wr_ptr) == mstart, "R1 init loads base", wr_ptr, mstart);
    chan_en = 1'b1;
    sink_on = 1'b1;

    // R2 / R3: two full bursts
    push_n(32);
    wait_bursts(2, 500);
    chk(int'(wr_ptr) == mstart + 32, "R3 pointer after two bursts", wr_ptr, mstart + 32);

    // R6: partial data waits, then flushes
    push_n(5);
    repeat (200) @(negedge clk);
    chk(bursts == 2 && !cmd_valid, "R6 no early flush", bursts, 2);
    chk(busy && !in_empty, "R9 busy with queued words", {busy, in_empty}, 2);
    wait_bursts(3, 400);
    chk(last_len == 5, "R6 flush length", last_len, 5);

    // R4 / R3: capped burst at the end, then wrap
    set_lim(mstart + 16);
    push_n(91);
    wait_bursts(9, 2000);
    chk(last_len == 11, "R4 burst capped at end", last_len, 11);
    chk(int'(wr_ptr) == mstart, "R3 wrap to base", wr_ptr, mstart);

    // R5: stall at limit, resume when limit moves
    push_n(16);
    repeat (400) @(negedge clk);
    chk(bursts == 9 && !cmd_valid, "R5 stalled at limit", bursts, 9);
    chk(int'(wr_ptr) == mstart, "R5 pointer held at limit", wr_ptr, mstart);
    set_lim(mstart + 32);
    wait_bursts(10, 200);
    chk(int'(wr_ptr) == mstart + 16, "R5 resumed after limit move", wr_ptr, mstart + 16);

    // R7: interrupt on crossing
    set_lim(32'h1300 >> 3);
    irq_addr = 29'(32'h1140 >> 3);
    irq_en = 1'b1;
    push_n(16);
    wait_bursts(11, 200);
    chk(!irq_out, "R7 no interrupt before address", irq_out, 0);
    push_n(16);
    wait_bursts(12, 200);
    chk(irq_out, "R7 interrupt on crossing", irq_out, 1);
    repeat (10) @(negedge clk);
    chk(irq_out, "R7 interrupt holds", irq_out, 1);
    irq_clear = 1'b1;
    @(negedge clk);
    irq_clear = 1'b0;
    irq_en = 1'b0;
    chk(!irq_out, "R7 clear drops interrupt", irq_out, 0);

    // R8 / R11: outstanding command completes with enable low
    auto_lim = 1'b1;
    set_lim(mptr);
    sink_on = 1'b0;
    push_n(16);
    for (int i = 0; i < 100 && !cmd_valid; i++) @(negedge clk);
    chk(cmd_valid, "R8 command offered", cmd_valid, 1);
    held_addr = cmd_addr;
    chan_en = 1'b0;
    repeat (20) @(negedge clk);
    chk(cmd_valid && cmd_addr == held_addr && cmd_len == 5'd16,
        "R11 command held", cmd_addr, held_addr);
    sink_on = 1'b1;
    wait_bursts(13, 200);
    chk(int'(wr_ptr) == mptr, "R8 outstanding completed", wr_ptr, mptr);
    push_n(16);
    repeat (400) @(negedge clk);
    chk(bursts == 13 && !cmd_valid, "R8 no issue while disabled", bursts, 13);
    chk(busy && !in_empty, "R9 busy while words wait", {busy, in_empty}, 2);
    chan_en = 1'b1;
    wait_bursts(14, 200);
    chk(!busy && in_empty, "R9 idle after drain", {busy, in_empty}, 1);

    // R10: fill the queue, offer an extra word, then drain across wraps
    sink_on = 1'b0;
    chan_en = 1'b0;
    push_n(1024);
    @(negedge clk);
    chk(!in_ready, "R10 ready low when full", in_ready, 0);
    in_data  = 64'hDEAD_BEEF_0BAD_F00D;
    in_valid = 1'b1;
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    chan_en = 1'b1;
    sink_on = 1'b1;
    wait_bursts(78, 8000);
    chk(exp_q.size() == 0, "R10 all stored words drained", exp_q.size(), 0);
    repeat (5) @(negedge clk);
    chk(!busy && in_empty, "R10 extra word not stored", {busy, in_empty}, 1);
    chk(!cmd_valid, "R10 no further command", cmd_valid, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule